// File: doc/BRIEF.md
# Control-Register Port Write Master

This block carries out a single write into a register that sits inside a PHY. The register is reached through a narrow parallel port that uses a request/acknowledge handshake. A caller presents a 16-bit register address and a 16-bit value, then pulses `start_i`. The block drives a 20-bit request word towards the PHY and watches a single acknowledge line coming back. When the write has finished it raises `done_o` for one cycle. If the PHY stops responding, it raises `err_o` for one cycle together with a code that says which acknowledge edge never arrived.

A write is made of three full four-phase handshakes, always in the same order:

1. The address is latched using the address-capture strobe.
2. The value is latched using the data-capture strobe.
3. The value is committed using the write strobe.

Before each of the two capture handshakes, the value is placed on the bus for one cycle with every strobe low. Each wait for an acknowledge edge is bounded by its own timeout. The timeout is built from a clock-cycle divider that produces a polling tick, so the interval can be set for any system clock. When a timeout fires, no later phase of the write is run.

Top module: `ctlreg_wr_master`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `req_o` is all zeros, `busy_o`, `done_o` and `err_o` are low, and `err_code_o` is 0.
- R2: The layout of `req_o` is fixed. Bit 0 is the address-capture strobe and bit 1 is the data-capture strobe. Bits [17:2] carry the 16-bit value. Bit 18 is the read strobe, which is never raised. Bit 19 is the write strobe. At most one strobe is high at any time.
- R3: Each handshake keeps its strobe high until `ack_i` is seen high. On the cycle after that, the strobe drops while the value is kept on the bus. The block then waits for `ack_i` to go low before it moves on.
- R4: A write runs three handshakes in this order: the address with the address-capture strobe, the value with the data-capture strobe, and the value again with the write strobe. `done_o` follows the third handshake.
- R5: Before each capture strobe rises, the value it captures is driven for one cycle with no strobe set. The value field does not change during any cycle in which a strobe is high.
- R6: If `ack_i` does not rise within the wait window, `err_o` pulses with `err_code_o` = 1. The strobe is removed and no later handshake is started.
- R7: If `ack_i` does not fall within the wait window after a strobe is dropped, `err_o` pulses with `err_code_o` = 2, and no later handshake is started.
- R8: `start_i` is ignored while `busy_o` is high. The write in progress keeps its own address and value, and it completes exactly once.
- R9: `done_o` and `err_o` are single-cycle pulses and are never high together. From the cycle they appear, `req_o` is all zeros and `busy_o` is low.
- R10: The wait window is exactly POLL_LIMIT × TICK_CYCLES clock cycles, counted from the cycle in which the wait begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a write; sampled only when idle |
| addr_i | input | 16 | Target register address, sampled with start |
| wdata_i | input | 16 | Value to write, sampled with start |
| ack_i | input | 1 | Acknowledge from the PHY port |
| req_o | output | 20 | Request word: strobes and value field (layout in R2) |
| busy_o | output | 1 | A write is in progress |
| done_o | output | 1 | One-cycle pulse: write completed |
| err_o | output | 1 | One-cycle pulse: write aborted on timeout |
| err_code_o | output | 2 | Abort cause: 1 ack never rose, 2 ack never fell |

## Verification
The assertions cover the rules that hold on every cycle:
- only one strobe is high, and the read strobe never rises;
- the strobe drops the cycle after an acknowledge is seen;
- the value stays stable under a strobe, and a capture strobe rises only out of an all-low strobe state;
- done and error are short pulses that never coincide;
- a start taken while idle makes the block busy.

Some properties can only be shown by the bench's scenarios:
- the full three-phase order, with the right address and value in each phase;
- the exact length of each strobe for a given responder delay;
- the length of the timeout window;
- the fact that no phase follows an abort;
- the fact that a second start during a write is lost.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int DIN_W = 16;
    localparam int REQ_W = DIN_W + 4;

    // Request word, MSB first: write(19) read(18) value(17:2) cap_data(1) cap_addr(0)
    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [DIN_W-1:0] din;
        logic             cap_data;
        logic             cap_addr;
    } ctl_req_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRESET,
        ST_RAISE,
        ST_RELEASE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_COMMIT
    } phase_t;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_ACK_RISE = 2'd1,
        ERR_ACK_FALL = 2'd2
    } err_code_t;

    // Build the request word for one phase, with or without its strobe.
    function automatic ctl_req_t make_req(phase_t ph, logic [DIN_W-1:0] value, logic strobe);
        ctl_req_t r;
        r     = '0;
        r.din = value;
        if (strobe) begin
            case (ph)
                PH_ADDR:   r.cap_addr = 1'b1;
                PH_DATA:   r.cap_data = 1'b1;
                PH_COMMIT: r.wr       = 1'b1;
                default:   r.wr       = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ctlreg_poll_timer.sv
module ctlreg_poll_timer #(
    parameter int TICK_CYCLES = 100,
    parameter int POLL_LIMIT  = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CYC_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int POLL_W = (POLL_LIMIT  > 1) ? $clog2(POLL_LIMIT)  : 1;

    logic              tick;
    logic [POLL_W-1:0] poll_q;

    generate
        if (TICK_CYCLES > 1) begin : g_div
            logic [CYC_W-1:0] cyc_q;
            always_ff @(posedge clk) begin
                if (rst || restart || !run) begin
                    cyc_q <= '0;
                end else if (cyc_q == CYC_W'(TICK_CYCLES - 1)) begin
                    cyc_q <= '0;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end
            assign tick = run && (cyc_q == CYC_W'(TICK_CYCLES - 1));
        end else begin : g_nodiv
            assign tick = run;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            poll_q <= '0;
        end else if (tick) begin
            poll_q <= poll_q + 1'b1;
        end
    end

    assign expired = tick && (poll_q == POLL_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/ctlreg_wr_seq.sv
module ctlreg_wr_seq
    import ctlreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIN_W-1:0] addr,
    input  logic [DIN_W-1:0] wdata,
    input  logic             ack,
    input  logic             expired,
    output ctl_req_t         req,
    output logic             busy,
    output logic             done,
    output logic             err,
    output err_code_t        err_code,
    output logic             tmr_restart,
    output logic             tmr_run
);
    seq_state_t       state_q, state_d;
    phase_t           phase_q, phase_d;
    logic [DIN_W-1:0] addr_q, data_q;
    ctl_req_t         req_q, req_d;
    logic             done_q, done_d, err_q, err_d;
    err_code_t        code_q, code_d;
    logic [DIN_W-1:0] cur_val;

    assign cur_val = (phase_q == PH_ADDR) ? addr_q : data_q;

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        req_d   = req_q;
        done_d  = 1'b0;
        err_d   = 1'b0;
        code_d  = code_q;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PRESET;
                    phase_d = PH_ADDR;
                    req_d   = make_req(PH_ADDR, addr, 1'b0);
                    code_d  = ERR_NONE;
                end
            end
            ST_PRESET: begin
                state_d = ST_RAISE;
                req_d   = make_req(phase_q, cur_val, 1'b1);
            end
            ST_RAISE: begin
                if (ack) begin
                    state_d = ST_RELEASE;
                    req_d   = make_req(phase_q, cur_val, 1'b0);
                end else if (expired) begin
                    state_d = ST_IDLE;
                    req_d   = '0;
                    err_d   = 1'b1;
                    code_d  = ERR_ACK_RISE;
                end
            end
            ST_RELEASE: begin
                if (!ack) begin
                    case (phase_q)
                        PH_ADDR: begin
                            state_d = ST_PRESET;
                            phase_d = PH_DATA;
                            req_d   = make_req(PH_DATA, data_q, 1'b0);
                        end
                        PH_DATA: begin
                            state_d = ST_RAISE;
                            phase_d = PH_COMMIT;
                            req_d   = make_req(PH_COMMIT, data_q, 1'b1);
                        end
                        default: begin
                            state_d = ST_IDLE;
                            req_d   = '0;
                            done_d  = 1'b1;
                        end
                    endcase
                end else if (expired) begin
                    state_d = ST_IDLE;
                    req_d   = '0;
                    err_d   = 1'b1;
                    code_d  = ERR_ACK_FALL;
                end
            end
            default: begin
                state_d = ST_IDLE;
                req_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_ADDR;
            addr_q  <= '0;
            data_q  <= '0;
            req_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= ERR_NONE;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            req_q   <= req_d;
            done_q  <= done_d;
            err_q   <= err_d;
            code_q  <= code_d;
            if (state_q == ST_IDLE && start) begin
                addr_q <= addr;
                data_q <= wdata;
            end
        end
    end

    assign tmr_restart = (state_d != state_q);
    assign tmr_run     = (state_q == ST_RAISE) || (state_q == ST_RELEASE);
    assign req         = req_q;
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign err         = err_q;
    assign err_code    = code_q;

endmodule

// File: rtl/ctlreg_wr_master.sv
module ctlreg_wr_master
    import ctlreg_pkg::*;
#(
    parameter int TICK_CYCLES = 100,
    parameter int POLL_LIMIT  = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DIN_W-1:0] addr_i,
    input  logic [DIN_W-1:0] wdata_i,
    input  logic             ack_i,
    output logic [REQ_W-1:0] req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [1:0]       err_code_o
);
    ctl_req_t  req_s;
    err_code_t code_s;
    logic      tmr_restart, tmr_run, tmr_expired;

    ctlreg_poll_timer #(
        .TICK_CYCLES (TICK_CYCLES),
        .POLL_LIMIT  (POLL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    ctlreg_wr_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start_i),
        .addr        (addr_i),
        .wdata       (wdata_i),
        .ack         (ack_i),
        .expired     (tmr_expired),
        .req         (req_s),
        .busy        (busy_o),
        .done        (done_o),
        .err         (err_o),
        .err_code    (code_s),
        .tmr_restart (tmr_restart),
        .tmr_run     (tmr_run)
    );

    assign req_o      = req_s;
    assign err_code_o = code_s;

endmodule

// File: rtl/ctlreg_wr_master_chk.sv
module ctlreg_wr_master_chk
    import ctlreg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             ack_i,
    input logic [REQ_W-1:0] req_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [1:0]       err_code_o
);
    logic [2:0] strb;
    assign strb = {req_o[19], req_o[1], req_o[0]};

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (req_o == '0 && !busy_o && !done_o && !err_o && err_code_o == 2'd0)); // R1
    AST_READ_LOW: assert property (@(posedge clk) disable iff (rst) !req_o[18]); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $countones(strb) <= 1); // R2
    AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (rst) ((|strb) && ack_i) |=> (strb == 3'b000)); // R3
    AST_VALUE_HELD: assert property (@(posedge clk) disable iff (rst) (|strb) |-> $stable(req_o[17:2])); // R5
    AST_CAP_FROM_QUIET: assert property (@(posedge clk) disable iff (rst) ($rose(req_o[0]) || $rose(req_o[1])) |-> ($past(strb) == 3'b000)); // R5
    AST_ERR_CODED: assert property (@(posedge clk) disable iff (rst) err_o |-> (err_code_o != 2'd0)); // R6
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o) |=> busy_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R9
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst) err_o |=> !err_o); // R9
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(done_o && err_o)); // R9
    AST_END_QUIET: assert property (@(posedge clk) disable iff (rst) (done_o || err_o) |-> (req_o == '0 && !busy_o)); // R9

endmodule

bind ctlreg_wr_master ctlreg_wr_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ack_i      (ack_i),
    .req_o      (req_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .err_code_o (err_code_o)
);

// File: tb/ctlreg_wr_master_test.sv
`timescale 1ns/1ps
module ctlreg_wr_master_test;
    localparam int TICK = 4;
    localparam int LIM  = 8;
    localparam int WIN  = TICK * LIM;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        ack_i = 1'b0;
    logic [19:0] req_o;
    logic        busy_o, done_o, err_o;
    logic [1:0]  err_code_o;

    int n_chk = 0;
    int n_fail = 0;

    // responder controls
    int       ack_delay = 2;
    logic [3:0] blk_rise = 4'b0000;   // {wr, rd, cap_data, cap_addr}
    bit       blk_fall = 1'b0;

    // monitor log
    logic [3:0]  lg_strb [0:63];
    logic [15:0] lg_din  [0:63];
    bit          lg_pre  [0:63];
    int          lg_len  [0:63];
    int          lg_n = 0;
    int          done_cnt = 0;
    int          err_cnt = 0;

    ctlreg_wr_master #(.TICK_CYCLES(TICK), .POLL_LIMIT(LIM)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .ack_i(ack_i), .req_o(req_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .err_code_o(err_code_o)
    );

    always #5 clk = ~clk;

    // PHY-side responder
    initial begin
        int cnt;
        logic [3:0] s;
        cnt = 0;
        forever begin
            @(negedge clk);
            s = {req_o[19], req_o[18], req_o[1], req_o[0]};
            if (s != 0 && !ack_i) begin
                cnt++;
                if (cnt >= ack_delay && (s & blk_rise) == 0) begin
                    ack_i = 1'b1;
                    cnt = 0;
                end
            end else if (s == 0 && ack_i) begin
                cnt++;
                if (cnt >= ack_delay && !blk_fall) begin
                    ack_i = 1'b0;
                    cnt = 0;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // monitor
    initial begin
        logic [3:0]  s, prev_s;
        logic [15:0] prev_din;
        prev_s = '0;
        prev_din = '0;
        forever begin
            @(negedge clk);
            s = {req_o[19], req_o[18], req_o[1], req_o[0]};
            if (s != 0 && prev_s == 0) begin
                lg_strb[lg_n] = s;
                lg_din[lg_n]  = req_o[17:2];
                lg_pre[lg_n]  = (prev_din == req_o[17:2]);
                lg_len[lg_n]  = 1;
                lg_n++;
            end else if (s != 0) begin
                lg_len[lg_n-1]++;
            end
            if (done_o) done_cnt++;
            if (err_o) err_cnt++;
            prev_s = s;
            prev_din = req_o[17:2];
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        start_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 2000; i++) begin
            if (done_o || err_o) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_o == 0 && !busy_o && !done_o && !err_o && err_code_o == 0, "R1 in reset", req_o, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_o == 0 && !busy_o && !done_o && !err_o && err_code_o == 0, "R1 after reset", req_o, 0);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [15:0] d, input int dly);
        int b, dc;
        b = lg_n; dc = done_cnt;
        ack_delay = dly;
        pulse_start(a, d);
        wait_end();
        chk(done_o == 1'b1 && err_o == 1'b0, "R4 done", {done_o, err_o}, 2);
        chk(lg_n - b == 3, "R4 three handshakes", lg_n - b, 3);
        chk(lg_strb[b] == 4'b0001 && lg_din[b] == a, "R2 R4 address phase", {lg_strb[b], lg_din[b]}, {4'b0001, a});
        chk(lg_strb[b+1] == 4'b0010 && lg_din[b+1] == d, "R2 R4 data phase", {lg_strb[b+1], lg_din[b+1]}, {4'b0010, d});
        chk(lg_strb[b+2] == 4'b1000 && lg_din[b+2] == d, "R2 R4 commit phase", {lg_strb[b+2], lg_din[b+2]}, {4'b1000, d});
        chk(lg_pre[b] && lg_pre[b+1], "R5 preset before capture", {lg_pre[b], lg_pre[b+1]}, 3);
        chk(lg_pre[b+2], "R3 value kept into commit", lg_pre[b+2], 1);
        for (int i = 0; i < 3; i++)
            chk(lg_len[b+i] == dly, "R3 strobe held until ack", lg_len[b+i], dly);
        @(negedge clk);
        chk(!done_o && req_o == 0 && !busy_o, "R9 done pulse then quiet", {done_o, req_o}, 0);
        chk(done_cnt - dc == 1, "R9 one done", done_cnt - dc, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_start_busy();
        int b, dc;
        b = lg_n; dc = done_cnt;
        ack_delay = 3;
        pulse_start(16'h1357, 16'h2468);
        repeat (3) @(negedge clk);
        start_i = 1'b1; addr_i = 16'hdead; wdata_i = 16'hbeef;
        @(negedge clk);
        start_i = 1'b0;
        wait_end();
        repeat (12) @(negedge clk);
        chk(lg_n - b == 3, "R8 single write", lg_n - b, 3);
        chk(lg_din[b] == 16'h1357 && lg_din[b+2] == 16'h2468, "R8 original operands", lg_din[b], 16'h1357);
        chk(done_cnt - dc == 1, "R8 one completion", done_cnt - dc, 1);
    endtask

    task automatic t_rise_timeout(input logic [3:0] mask, input int exp_n);
        int b, dc, ec;
        b = lg_n; dc = done_cnt; ec = err_cnt;
        ack_delay = 2; blk_rise = mask;
        pulse_start(16'h00a5, 16'h5a00);
        wait_end();
        chk(err_o && err_code_o == 2'd1, "R6 rise timeout code", err_code_o, 1);
        chk(lg_len[lg_n-1] == WIN, "R10 wait window length", lg_len[lg_n-1], WIN);
        @(negedge clk);
        chk(!err_o && req_o == 0 && !busy_o, "R9 err pulse then quiet", {err_o, req_o}, 0);
        repeat (10) @(negedge clk);
        chk(lg_n - b == exp_n, "R6 no later phase", lg_n - b, exp_n);
        chk(done_cnt == dc && err_cnt - ec == 1, "R6 no done", done_cnt - dc, 0);
        blk_rise = 4'b0000;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_fall_timeout();
        int b, dc;
        b = lg_n; dc = done_cnt;
        ack_delay = 2; blk_fall = 1'b1;
        pulse_start(16'h0f0f, 16'hf0f0);
        wait_end();
        chk(err_o && err_code_o == 2'd2, "R7 fall timeout code", err_code_o, 2);
        repeat (10) @(negedge clk);
        chk(lg_n - b == 1 && lg_len[b] == 2, "R7 no later phase", lg_n - b, 1);
        chk(done_cnt == dc, "R7 no done", done_cnt - dc, 0);
        blk_fall = 1'b0;
        repeat (6) @(negedge clk);
        chk(ack_i == 1'b0 && req_o == 0, "R7 port quiet after abort", ack_i, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_write(16'h1015, 16'ha3c1, 2);
        t_write(16'hffff, 16'h0001, 1);
        t_write(16'h0012, 16'h8000, 5);
        t_start_busy();
        t_rise_timeout(4'b1000, 3);
        t_rise_timeout(4'b0001, 1);
        t_fall_timeout();
        t_write(16'h4321, 16'h1234, 3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule